// File: doc/BRIEF.md
# Energy to Pulse-Rate Converter

This block takes a stream of signed instantaneous power samples, each marked by a one-cycle strobe. It scales every sample by a small signed gain trim and integrates the result into energy. It emits three kinds of active-low pulse. Two low-rate energy outputs can drive a stepper motor or a bidirectional mechanical counter. A high-rate calibration output runs at a fixed full-scale frequency. A sticky flag reports the direction of the energy flow.

Two independent accumulators share the trimmed sample. The low-rate accumulator uses a quantum that follows the selected full-scale pulse rate. The high-rate accumulator uses a fixed quantum. Each quantum is derived from the full-scale sample value and the sample rate, so that a full-scale sample stream produces exactly the selected rate. Low-rate pulse widths are counted in ticks of an external clock enable, which lets the same logic serve real-time millisecond widths and shortened simulation runs. A pulse that falls due while an earlier one is still being shown waits in a short queue.

Top module: `energy_pulse_gen`

## Requirements
- R1: While reset is low and in the cycle after it is released, `e1_n`, `e2_n`, `hf_n` and `neg_n` are all high, and both accumulators hold zero.
- R2: Each sample taken with `smp_valid` high is scaled to s = p + floor(p * trim / 2^TRIM_FRAC), where p is `smp_power` and trim is `gain_trim`, both two's complement. A cycle with `smp_valid` low changes no accumulator and no flag.
- R3: The low-rate accumulator adds s. If the sum is at least Q, one positive event is raised and Q is subtracted. Otherwise, if the sum is at most -Q, one negative event is raised and Q is added. The remainder is kept. Q = FULL_SCALE * SAMPLE_RATE * 4 / m, where `rate_code` 0,1,2,3,4 select m = 1,2,4,8,16 (0.25, 0.5, 1, 2 and 4 Hz) and codes 5 to 7 select m = 64 (16 Hz).
- R4: The high-rate accumulator follows the same rule with Q = FULL_SCALE * SAMPLE_RATE / HF_RATE. Each of its events drives `hf_n` low for exactly one clock cycle, in the cycle after the sample edge.
- R5: A low-rate pulse lasts a whole number of `width_tick` pulses: 15 for codes 5 to 7, 125 for code 4, 125 for code 3 in counter format, and 250 otherwise.
- R6: In stepper format (`out_fmt` = 0), pulses alternate E1, E2, E1, ... whatever their sign, and the first pulse after reset goes to E1.
- R7: In counter format (`out_fmt` = 1), positive events pulse `e1_n` and negative events pulse `e2_n`.
- R8: An event that comes due while a low-rate pulse is active is held in a queue of PEND_DEPTH entries and shown later in arrival order. `e1_n` and `e2_n` are never low together.
- R9: `neg_n` goes low after a sample whose scaled value is negative and goes high after one whose scaled value is positive. A zero sample leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_tick | input | 1 | Clock enable that times low-rate pulse widths |
| smp_valid | input | 1 | Strobe: a new power sample is present |
| smp_power | input | PW | Signed instantaneous power sample |
| out_fmt | input | 1 | 0 = stepper alternation, 1 = counter split by sign |
| rate_code | input | 3 | Full-scale low-rate pulse frequency selection |
| gain_trim | input | TRIM_W | Signed gain trim in units of 2^-TRIM_FRAC |
| e1_n | output | 1 | First low-rate energy pulse, active low |
| e2_n | output | 1 | Second low-rate energy pulse, active low |
| hf_n | output | 1 | High-rate calibration pulse, active low |
| neg_n | output | 1 | Energy direction flag, low for negative |

## Verification
A wrong accumulator remainder or a wrong trim product does not show at once. It appears as one pulse too many or too few, and only after a whole quantum of energy has built up. On the high-rate output that takes about ten samples; on the low-rate outputs it takes hundreds. The bench therefore compares pulse counts over long stretches of samples and carries a model of the remainders across phases. A wrong alternation phase, a wrong sign steering or a lost queue entry shows on the very next low-rate pulse, as a pulse on the wrong pin or an expected pulse that never arrives. A wrong width count shows when that pulse ends.

// File: rtl/epg_pkg.sv
package epg_pkg;

   typedef enum logic {
      FMT_STEPPER = 1'b0,
      FMT_COUNTER = 1'b1
   } fmt_e;

   localparam int WIDTH_LONG  = 250;
   localparam int WIDTH_MID   = 125;
   localparam int WIDTH_SHORT = 15;
   localparam int TMR_W       = $clog2(WIDTH_LONG + 1);
   localparam int RATE_SEL_W  = 3;
   localparam int FAST_SHIFT  = 6;

   // divisor exponent of the low-rate quantum for a rate code
   function automatic logic [2:0] rate_shift(input logic [RATE_SEL_W-1:0] code);
      if (code < 3'd5) return code;
      return 3'(FAST_SHIFT);
   endfunction

   // pulse width in width ticks for a format and a rate code
   function automatic logic [TMR_W-1:0] pulse_width(input logic fmt,
                                                     input logic [RATE_SEL_W-1:0] code);
      if (code >= 3'd5)                      return TMR_W'(WIDTH_SHORT);
      if (code == 3'd4)                      return TMR_W'(WIDTH_MID);
      if (fmt == FMT_COUNTER && code == 3'd3) return TMR_W'(WIDTH_MID);
      return TMR_W'(WIDTH_LONG);
   endfunction

endpackage

// File: rtl/epg_scale.sv
module epg_scale #(
   parameter int PW        = 16,
   parameter int TRIM_W    = 6,
   parameter int TRIM_FRAC = 9,
   localparam int SW       = PW + 2
) (
   input  logic signed [PW-1:0]     power,
   input  logic signed [TRIM_W-1:0] trim,
   output logic signed [SW-1:0]     scaled
);

   localparam int PROD_W = PW + TRIM_W;

   if (TRIM_W < 2) begin : g_bad_trim_w
      $error("epg_scale: TRIM_W must be at least 2");
   end
   if (TRIM_FRAC < TRIM_W) begin : g_bad_trim_frac
      $error("epg_scale: trim magnitude must stay below one");
   end

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] adj;

   always_comb begin
      prod   = power * trim;
      adj    = prod >>> TRIM_FRAC;
      scaled = $signed({{2{power[PW-1]}}, power}) + $signed(adj[SW-1:0]);
   end

endmodule

// File: rtl/epg_accum.sv
module epg_accum #(
   parameter int SW    = 18,
   parameter int ACC_W = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [SW-1:0] sample,
   input  logic [ACC_W-1:0]     quantum,
   output logic                 evt_pos,
   output logic                 evt_neg
);

   if (ACC_W <= SW + 1) begin : g_bad_acc_w
      $error("epg_accum: accumulator must be wider than the sample");
   end

   logic signed [ACC_W-1:0] acc, sum, qs, acc_nx;
   logic                    up, dn;

   always_comb begin
      qs     = $signed(quantum);
      sum    = acc + $signed({{(ACC_W-SW){sample[SW-1]}}, sample});
      up     = (sum >= qs);
      dn     = (sum <= -qs);
      acc_nx = sum;
      if (up)      acc_nx = sum - qs;
      else if (dn) acc_nx = sum + qs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         evt_pos <= 1'b0;
         evt_neg <= 1'b0;
      end else begin
         evt_pos <= en && up;
         evt_neg <= en && dn && !up;
         if (en) acc <= acc_nx;
      end
   end

   assert_one_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_pos && evt_neg));
   assert_evt_from_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pos || evt_neg) |-> $past(en));
   assert_idle_keeps_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(acc));

endmodule

// File: rtl/epg_shaper.sv
module epg_shaper
   import epg_pkg::*;
#(
   parameter int PEND_DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             fmt,
   input  logic [TMR_W-1:0] width,
   input  logic             push,
   input  logic             push_dir,
   output logic             out1_n,
   output logic             out2_n
);

   localparam int CNT_W = $clog2(PEND_DEPTH + 1);

   if (PEND_DEPTH < 1) begin : g_bad_depth
      $error("epg_shaper: PEND_DEPTH must be at least 1");
   end

   logic [PEND_DEPTH-1:0] dq, dq_nx;
   logic [CNT_W-1:0]      cnt, cnt_nx;
   logic [TMR_W-1:0]      timer;
   logic                  busy, sel, phase, pop;

   always_comb begin
      pop    = !busy && (cnt != '0);
      dq_nx  = dq;
      cnt_nx = cnt;
      if (pop) begin
         dq_nx  = dq >> 1;
         cnt_nx = cnt - CNT_W'(1);
      end
      if (push && (cnt_nx < CNT_W'(PEND_DEPTH))) begin
         for (int i = 0; i < PEND_DEPTH; i++) begin
            if (CNT_W'(i) == cnt_nx) dq_nx[i] = push_dir;
         end
         cnt_nx = cnt_nx + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq    <= '0;
         cnt   <= '0;
         timer <= '0;
         busy  <= 1'b0;
         sel   <= 1'b0;
         phase <= 1'b0;
      end else begin
         dq  <= dq_nx;
         cnt <= cnt_nx;
         if (pop) begin
            busy  <= 1'b1;
            timer <= width;
            if (fmt == FMT_STEPPER) begin
               sel   <= phase;
               phase <= ~phase;
            end else begin
               sel <= dq[0];
            end
         end else if (busy && tick) begin
            timer <= timer - TMR_W'(1);
            if (timer == TMR_W'(1)) busy <= 1'b0;
         end
      end
   end

   assign out1_n = ~(busy & ~sel);
   assign out2_n = ~(busy & sel);

   assert_end_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick));
   assert_queue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(PEND_DEPTH));
   assert_start_from_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cnt) != '0));

endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
   import epg_pkg::*;
#(
   parameter int PW          = 16,
   parameter int FULL_SCALE  = 32767,
   parameter int SAMPLE_RATE = 100000,
   parameter int HF_RATE     = 10000,
   parameter int TRIM_W      = 6,
   parameter int TRIM_FRAC   = 9,
   parameter int PEND_DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              width_tick,
   input  logic              smp_valid,
   input  logic [PW-1:0]     smp_power,
   input  logic              out_fmt,
   input  logic [2:0]        rate_code,
   input  logic [TRIM_W-1:0] gain_trim,
   output logic              e1_n,
   output logic              e2_n,
   output logic              hf_n,
   output logic              neg_n
);

   localparam int     SW     = PW + 2;
   localparam longint QBASE  = longint'(FULL_SCALE) * longint'(SAMPLE_RATE) * 64'sd4;
   localparam longint Q_HF   = longint'(FULL_SCALE) * longint'(SAMPLE_RATE) / longint'(HF_RATE);
   localparam int     ACC_W  = $clog2(QBASE) + 3;
   localparam int     N_ACC  = 2;

   if (FULL_SCALE <= 0 || longint'(FULL_SCALE) >= (64'sd1 <<< (PW - 1))) begin : g_bad_fs
      $error("energy_pulse_gen: FULL_SCALE must fit the sample width");
   end
   if ((QBASE >>> FAST_SHIFT) < 8 * longint'(FULL_SCALE)) begin : g_bad_lf
      $error("energy_pulse_gen: SAMPLE_RATE too low for one event per sample");
   end
   if (Q_HF < 8 * longint'(FULL_SCALE)) begin : g_bad_hf
      $error("energy_pulse_gen: HF_RATE too high for one event per sample");
   end

   logic signed [SW-1:0] scaled;
   logic [ACC_W-1:0]     q_lf, q_hf;
   logic [ACC_W-1:0]     quantum [N_ACC];
   logic [N_ACC-1:0]     ev_p, ev_n;

   epg_scale #(.PW(PW), .TRIM_W(TRIM_W), .TRIM_FRAC(TRIM_FRAC)) scale_i (
      .power  ($signed(smp_power)),
      .trim   ($signed(gain_trim)),
      .scaled (scaled)
   );

   assign q_lf       = ACC_W'(QBASE) >> rate_shift(rate_code);
   assign q_hf       = ACC_W'(Q_HF);
   assign quantum[0] = q_lf;
   assign quantum[1] = q_hf;

   for (genvar g = 0; g < N_ACC; g++) begin : g_acc
      epg_accum #(.SW(SW), .ACC_W(ACC_W)) accum_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (smp_valid),
         .sample  (scaled),
         .quantum (quantum[g]),
         .evt_pos (ev_p[g]),
         .evt_neg (ev_n[g])
      );
   end

   epg_shaper #(.PEND_DEPTH(PEND_DEPTH)) shaper_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (width_tick),
      .fmt      (out_fmt),
      .width    (pulse_width(out_fmt, rate_code)),
      .push     (ev_p[0] | ev_n[0]),
      .push_dir (ev_n[0]),
      .out1_n   (e1_n),
      .out2_n   (e2_n)
   );

   assign hf_n = ~(ev_p[1] | ev_n[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         neg_n <= 1'b1;
      else if (smp_valid && scaled != '0) neg_n <= ~scaled[SW-1];
   end

   assert_never_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
      e1_n || e2_n);
   assert_hf_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hf_n |-> $past(smp_valid));
   assert_hf_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hf_n |=> hf_n);
   assert_neg_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && scaled < 0) |=> !neg_n);
   assert_neg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && scaled > 0) |=> neg_n);
   assert_neg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(neg_n));

endmodule

// File: tb/energy_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module energy_pulse_gen_tb_top;

   localparam int     PW    = 16;
   localparam int     FS    = 1000;
   localparam int     SR    = 1000;
   localparam int     HFR   = 100;
   localparam int     TW    = 6;
   localparam int     TF    = 9;
   localparam longint QB    = longint'(FS) * SR * 4;
   localparam longint QH    = longint'(FS) * SR / HFR;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          width_tick;
   logic          smp_valid;
   logic [PW-1:0] smp_power;
   logic          out_fmt;
   logic [2:0]    rate_code;
   logic [TW-1:0] gain_trim;
   logic          e1_n, e2_n, hf_n, neg_n;

   always #5 clk = ~clk;

   energy_pulse_gen #(.PW(PW), .FULL_SCALE(FS), .SAMPLE_RATE(SR), .HF_RATE(HFR),
                      .TRIM_W(TW), .TRIM_FRAC(TF), .PEND_DEPTH(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .width_tick(width_tick), .smp_valid(smp_valid),
      .smp_power(smp_power), .out_fmt(out_fmt), .rate_code(rate_code),
      .gain_trim(gain_trim), .e1_n(e1_n), .e2_n(e2_n), .hf_n(hf_n), .neg_n(neg_n)
   );

   typedef struct {
      int    out_id;
      int    wmin;
      int    wmax;
      string req;
   } exp_t;

   exp_t   expq[$];
   int     checks = 0, errors = 0;
   bit     done = 1'b0;
   int     div = 1;
   longint m_lf = 0, m_hf = 0;
   int     m_phase = 0;
   int     hf_exp = 0, hf_seen = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int w_ticks(input int fmt, input int code);
      if (code >= 5) return 15;
      if (code == 4) return 125;
      if (fmt == 1 && code == 3) return 125;
      return 250;
   endfunction

   function automatic longint q_low(input int code);
      int m;
      case (code)
         0: m = 1;  1: m = 2;  2: m = 4;  3: m = 8;  4: m = 16;
         default: m = 64;
      endcase
      return QB / m;
   endfunction

   // driver: one sample, and the pulses it is expected to cause
   task automatic drive_sample(input int p, input int fmt, input int code, input int trim);
      longint s, q;
      @(negedge clk);
      smp_valid = 1'b1;
      smp_power = PW'(p);
      out_fmt   = fmt[0];
      rate_code = 3'(code);
      gain_trim = TW'(trim);
      s = longint'(p) + ((longint'(p) * longint'(trim)) >>> TF);
      q = q_low(code);
      m_lf += s;
      if (m_lf >= q || m_lf <= -q) begin
         exp_t e;
         bit   neg = (m_lf < 0);
         int   w   = w_ticks(fmt, code);
         m_lf = neg ? m_lf + q : m_lf - q;
         if (fmt == 0) begin
            e.out_id = m_phase; m_phase ^= 1; e.req = "R6";
         end else begin
            e.out_id = neg ? 1 : 0; e.req = "R7";
         end
         e.wmin = (w - 1) * div + 1;
         e.wmax = w * div;
         expq.push_back(e);
      end
      m_hf += s;
      if (m_hf >= QH)       begin m_hf -= QH; hf_exp++; end
      else if (m_hf <= -QH) begin m_hf += QH; hf_exp++; end
   endtask

   task automatic run_phase(input int p, input int n, input int fmt, input int code,
                            input int trim);
      for (int i = 0; i < n; i++) drive_sample(p, fmt, code, trim);
   endtask

   task automatic end_phase(input int cycles, input bit exp_neg_n, input string tag);
      @(negedge clk);
      smp_valid = 1'b0;
      check(neg_n == exp_neg_n, "R9", {tag, " direction flag"}, neg_n, exp_neg_n);
      repeat (cycles) @(negedge clk);
      check(expq.size() == 0, "R8", {tag, " pulses still owed"}, expq.size(), 0);
      check(hf_seen == hf_exp, "R4", {tag, " high-rate pulse count"}, hf_seen, hf_exp);
   endtask

   // tick generator
   initial begin
      int tc = 0;
      width_tick = 1'b0;
      forever begin
         @(negedge clk);
         tc++;
         if (tc >= div) begin tc = 0; width_tick = 1'b1; end
         else width_tick = 1'b0;
      end
   end

   // monitor: pops expected low-rate pulses and compares
   initial begin
      int wc[2] = '{0, 0};
      forever begin
         @(negedge clk);
         if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
               logic lv;
               lv = (k == 0) ? e1_n : e2_n;
               if (!lv) wc[k]++;
               else if (wc[k] > 0) begin
                  if (expq.size() == 0) begin
                     check(1'b0, "R8", "unexpected low-rate pulse on output", k + 1, 0);
                  end else begin
                     exp_t e;
                     e = expq.pop_front();
                     check(e.out_id == k, e.req, "pulse output", k + 1, e.out_id + 1);
                     check(wc[k] >= e.wmin && wc[k] <= e.wmax, "R5", "pulse width cycles",
                           wc[k], e.wmax);
                  end
                  wc[k] = 0;
               end
            end
            if (!hf_n) hf_seen++;
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      smp_valid = 1'b0;
      smp_power = '0;
      out_fmt   = 1'b0;
      rate_code = 3'd4;
      gain_trim = '0;
      repeat (4) @(negedge clk);
      // R1: outputs inactive in reset
      check(e1_n == 1'b1, "R1", "e1_n in reset", e1_n, 1);
      check(e2_n == 1'b1, "R1", "e2_n in reset", e2_n, 1);
      check(hf_n == 1'b1, "R1", "hf_n in reset", hf_n, 1);
      check(neg_n == 1'b1, "R1", "neg_n in reset", neg_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(e1_n && e2_n && hf_n && neg_n, "R1", "outputs after release",
            {e1_n, e2_n, hf_n, neg_n}, 4'hF);

      // R3 R5 R6: stepper 4 Hz, full scale positive
      run_phase(FS, 1000, 0, 4, 0);
      end_phase(800, 1'b1, "stepper 4Hz");

      // R7 R9: counter 16 Hz, full scale negative
      run_phase(-FS, 500, 1, 5, 0);
      end_phase(200, 1'b0, "counter negative");

      // R9: zero samples leave the flag low
      run_phase(0, 50, 1, 5, 0);
      end_phase(20, 1'b0, "zero samples");

      // R2: strobe low, samples ignored
      smp_power = PW'(FS);
      repeat (50) @(negedge clk);
      check(neg_n == 1'b0, "R2", "flag after ignored samples", neg_n, 0);
      check(hf_seen == hf_exp, "R2", "high-rate count after ignored samples", hf_seen, hf_exp);
      check(expq.size() == 0, "R2", "no pulse from ignored samples", expq.size(), 0);

      // R3 R7 R9: counter 16 Hz at 80 percent positive
      run_phase(800, 600, 1, 5, 0);
      end_phase(200, 1'b1, "counter 80 percent");

      // R2 R6: positive trim, stepper 1 Hz
      run_phase(FS, 2000, 0, 2, 26);
      end_phase(800, 1'b1, "positive trim");

      // R2 R7: negative trim, counter 2 Hz (width 125)
      run_phase(-FS, 1200, 1, 3, -26);
      end_phase(400, 1'b0, "negative trim");

      // R8: slow ticks so pulses queue up
      div = 4;
      run_phase(FS, 1000, 0, 4, 0);
      end_phase(3000, 1'b1, "queued pulses");
      div = 1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule